// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block gathers up to 32 interrupt sources and presents them to a processor through two request lines. One is a normal request and one is a fast request. Each source is the OR of a hardware request pin and a software-raised request bit. A per-source enable mask gates that combined request. A per-source steering bit then sends the result either to the normal line or to the fast line. Software reaches all state through a simple word-aligned register interface with separate read and write strobes. Read data is registered.

For the normal line the block also offers vectored dispatch. There are sixteen prioritised slots, and each binds a programmable source number to a handler address under its own enable bit. Reading the current-vector register returns the address of the highest-priority matching slot, or a default address when no slot matches. A successful read marks that slot as in service. From then on, slots of equal or lower priority cannot be granted until software writes the same register to end the service. A slot of higher priority can still be granted, so handlers may nest. Four read-only identification bytes allow software to recognise the cell.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every enable, steering, software-request, slot-control and test-control register reads 0. Both request outputs are low even when all hardware request pins are high.
- R2: Writing offset 0x010 sets the enable of each source whose data bit is 1, and writing offset 0x014 clears it. Zero data bits leave their enables unchanged. Offset 0x010 reads back the enable mask.
- R3: Writing offset 0x018 sets software requests and writing offset 0x01C clears them, with the same one-bits-only rule. Offset 0x018 reads back the requests, and a software request acts like a high hardware pin.
- R4: Offset 0x000 reads the normal status, which is (hardware OR software) AND enable AND NOT steering. The normal output is the OR of this status word, and a status bit falls at the clock edge that stores its enable clear.
- R5: Offset 0x00C holds the steering bits, where 1 selects the fast line. Offset 0x004 reads the fast status, which is (hardware OR software) AND enable AND steering. The fast output is the OR of this status word.
- R6: Slot n has an address register at 0x100+4n and a control register at 0x200+4n. In the control register, bit 5 is the slot enable and bits 4:0 are the bound source. Other control bits read 0.
- R7: A read of offset 0x030 returns the address of the lowest-numbered enabled, unblocked slot whose source is set in the normal status. If no such slot exists it returns the default address held at offset 0x034. Sources steered to the fast line never match.
- R8: A read of 0x030 that returns a slot address marks that slot in service, and a read that returns the default marks nothing. A slot is blocked while it or any lower-numbered slot is in service. Each write to 0x030 ends service of the lowest-numbered in-service slot.
- R9: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the identification word in bytes 0 to 3 in bits 7:0. Byte 0 is the least significant, and bits 19:12 of the assembled word are the vendor code.
- R10: Offset 0x300 is a one-bit test-control register that reads 0 after reset and reads back the last value written to bit 0.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| hw_irq_i | input | NUM_SRC | Hardware request lines, active high |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with 32 sources, 16 slots and 32-bit vector addresses, which is every source bit and every control field width. It supplies its own identification word with vendor code 0x43, so the byte order and the vendor field position are checked against a value the default does not carry. With all sixteen slots present, the bench can drive a nested sequence across slots 0, 2 and 5. That sequence covers preemption by a higher-priority slot, blocking at equal and lower priority, end of service in lowest-first order, and the default return for fast-steered or disabled bindings.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int RA_W = 12;
  localparam int DW   = 32;

  localparam logic [RA_W-1:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [RA_W-1:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [RA_W-1:0] OFS_STEER    = 12'h00C;
  localparam logic [RA_W-1:0] OFS_EN_SET   = 12'h010;
  localparam logic [RA_W-1:0] OFS_EN_CLR   = 12'h014;
  localparam logic [RA_W-1:0] OFS_SW_SET   = 12'h018;
  localparam logic [RA_W-1:0] OFS_SW_CLR   = 12'h01C;
  localparam logic [RA_W-1:0] OFS_VEC_CUR  = 12'h030;
  localparam logic [RA_W-1:0] OFS_VEC_DEF  = 12'h034;
  localparam logic [RA_W-1:0] OFS_TEST     = 12'h300;
  localparam logic [3:0]      PAGE_VADDR   = 4'h1;
  localparam logic [3:0]      PAGE_VCTL    = 4'h2;
  localparam logic [7:0]      PAGE_ID      = 8'hFE;

  typedef struct packed {
    logic irq_stat;
    logic fiq_stat;
    logic steer;
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic vec_cur;
    logic vec_def;
    logic vaddr;
    logic vctl;
    logic test;
    logic id;
  } regsel_t;

endpackage

// File: rtl/irqv_decode.sv
module irqv_decode
  import irqv_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int SLOT_W  = 4
) (
  input  logic [RA_W-1:0]   addr_i,
  output regsel_t           rs_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [1:0]        id_idx_o
);

  logic aligned;
  logic slot_ok;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign slot_ok = (int'(addr_i[7:2]) < NUM_VEC);

  always_comb begin
    rs_o          = '0;
    rs_o.irq_stat = (addr_i == OFS_IRQ_STAT);
    rs_o.fiq_stat = (addr_i == OFS_FIQ_STAT);
    rs_o.steer    = (addr_i == OFS_STEER);
    rs_o.en_set   = (addr_i == OFS_EN_SET);
    rs_o.en_clr   = (addr_i == OFS_EN_CLR);
    rs_o.sw_set   = (addr_i == OFS_SW_SET);
    rs_o.sw_clr   = (addr_i == OFS_SW_CLR);
    rs_o.vec_cur  = (addr_i == OFS_VEC_CUR);
    rs_o.vec_def  = (addr_i == OFS_VEC_DEF);
    rs_o.test     = (addr_i == OFS_TEST);
    rs_o.vaddr    = aligned && slot_ok && (addr_i[11:8] == PAGE_VADDR);
    rs_o.vctl     = aligned && slot_ok && (addr_i[11:8] == PAGE_VCTL);
    rs_o.id       = aligned && (addr_i[11:4] == PAGE_ID);
  end

  assign slot_o   = addr_i[SLOT_W+1:2];
  assign id_idx_o = addr_i[3:2];

endmodule

// File: rtl/irqv_srcregs.sv
module irqv_srcregs #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               steer_wr_i,
  input  logic               sw_set_i,
  input  logic               sw_clr_i,
  input  logic               test_wr_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_SRC-1:0] hw_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] steer_o,
  output logic [NUM_SRC-1:0] sw_o,
  output logic               test_o,
  output logic [NUM_SRC-1:0] irq_stat_o,
  output logic [NUM_SRC-1:0] fiq_stat_o
);

  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] steer_q;
  logic [NUM_SRC-1:0] sw_q, sw_d;
  logic               test_q;
  logic               en_ce, sw_ce;
  logic [NUM_SRC-1:0] pend;

  assign wbits = wdata_i[NUM_SRC-1:0];

  // next state
  always_comb begin
    en_d = en_q;
    if (en_set_i) en_d = en_d | wbits;
    if (en_clr_i) en_d = en_d & ~wbits;
    sw_d = sw_q;
    if (sw_set_i) sw_d = sw_d | wbits;
    if (sw_clr_i) sw_d = sw_d & ~wbits;
    en_ce = en_set_i | en_clr_i;
    sw_ce = sw_set_i | sw_clr_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      steer_q <= '0;
      sw_q    <= '0;
      test_q  <= 1'b0;
    end else begin
      if (en_ce)      en_q    <= en_d;
      if (steer_wr_i) steer_q <= wbits;
      if (sw_ce)      sw_q    <= sw_d;
      if (test_wr_i)  test_q  <= wdata_i[0];
    end
  end

  assign pend       = hw_i | sw_q;
  assign irq_stat_o = pend & en_q & ~steer_q;
  assign fiq_stat_o = pend & en_q & steer_q;
  assign en_o       = en_q;
  assign steer_o    = steer_q;
  assign sw_o       = sw_q;
  assign test_o     = test_q;

  AST_EN_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_set_i && !en_clr_i) |=> ((en_q & $past(wbits)) == $past(wbits))); // R2
  AST_EN_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> ((en_q & $past(wbits)) == '0)); // R2
  AST_SW_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i && !sw_clr_i) |=> ((sw_q & $past(wbits)) == $past(wbits))); // R3
  AST_SW_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> ((sw_q & $past(wbits)) == '0)); // R3
  AST_STAT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> (((irq_stat_o | fiq_stat_o) & $past(wbits)) == '0)); // R4

endmodule

// File: rtl/irqv_vecbank.sv
module irqv_vecbank #(
  parameter int NUM_VEC = 16,
  parameter int SLOT_W  = 4,
  parameter int SRC_W   = 5,
  parameter int VEC_W   = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            vaddr_wr_i,
  input  logic                            vctl_wr_i,
  input  logic                            def_wr_i,
  input  logic [SLOT_W-1:0]               slot_i,
  input  logic [31:0]                     wdata_i,
  output logic [NUM_VEC-1:0][VEC_W-1:0]   vaddr_o,
  output logic [NUM_VEC-1:0]              slot_en_o,
  output logic [NUM_VEC-1:0][SRC_W-1:0]   slot_src_o,
  output logic [VEC_W-1:0]                def_o
);

  logic [VEC_W-1:0] def_q;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_slot
    logic             addr_ce, ctl_ce;
    logic [VEC_W-1:0] addr_q;
    logic             en_q;
    logic [SRC_W-1:0] src_q;

    assign addr_ce = vaddr_wr_i && (slot_i == SLOT_W'(g));
    assign ctl_ce  = vctl_wr_i  && (slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        en_q   <= 1'b0;
        src_q  <= '0;
      end else begin
        if (addr_ce) addr_q <= wdata_i[VEC_W-1:0];
        if (ctl_ce) begin
          en_q  <= wdata_i[SRC_W];
          src_q <= wdata_i[SRC_W-1:0];
        end
      end
    end

    assign vaddr_o[g]    = addr_q;
    assign slot_en_o[g]  = en_q;
    assign slot_src_o[g] = src_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       def_q <= '0;
    else if (def_wr_i) def_q <= wdata_i[VEC_W-1:0];
  end

  assign def_o = def_q;

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int NUM_VEC = 16,
  parameter int SRC_W   = 5,
  parameter int VEC_W   = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            irq_stat_i,
  input  logic [NUM_VEC-1:0]            slot_en_i,
  input  logic [NUM_VEC-1:0][SRC_W-1:0] slot_src_i,
  input  logic [NUM_VEC-1:0][VEC_W-1:0] vaddr_i,
  input  logic [VEC_W-1:0]              def_i,
  input  logic                          ack_i,
  input  logic                          eoi_i,
  output logic [VEC_W-1:0]              vec_o
);

  localparam logic [NUM_VEC-1:0] ONE_V = NUM_VEC'(1);

  logic [NUM_VEC-1:0] hit, blk, elig, grant;
  logic [NUM_VEC-1:0] insvc_q, insvc_d;
  logic               any, insvc_ce;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_match
    assign hit[g] = slot_en_i[g] & irq_stat_i[slot_src_i[g]];
    if (g == 0) begin : g_first
      assign blk[g] = insvc_q[g];
    end else begin : g_rest
      assign blk[g] = blk[g-1] | insvc_q[g];
    end
  end

  assign elig  = hit & ~blk;
  assign grant = elig & (~elig + ONE_V);
  assign any   = |elig;

  always_comb begin
    vec_o = def_i;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i]) vec_o = vaddr_i[i];
    end
  end

  // next state of the in-service set
  always_comb begin
    insvc_d = insvc_q;
    if (eoi_i)        insvc_d = insvc_d & (insvc_d - ONE_V);
    if (ack_i && any) insvc_d = insvc_d | grant;
    insvc_ce = eoi_i | (ack_i & any);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       insvc_q <= '0;
    else if (insvc_ce) insvc_q <= insvc_d;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R7
  AST_ACK_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && any && !eoi_i) |=> ((insvc_q & $past(grant)) == $past(grant))); // R8
  AST_EOI_POPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (insvc_q != '0)) |=>
      ($countones(insvc_q) == $countones($past(insvc_q)) - 1)); // R8
  AST_DEFAULT_NO_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !any && !eoi_i) |=> $stable(insvc_q)); // R8

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int          NUM_SRC = 32,
  parameter int          NUM_VEC = 16,
  parameter int          VEC_W   = 32,
  parameter logic [31:0] CELL_ID = 32'h0004_1192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [11:0]        addr_i,
  input  logic               wr_i,
  input  logic [31:0]        wdata_i,
  input  logic               rd_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] hw_irq_i,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int SLOT_W = $clog2(NUM_VEC);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  regsel_t                        rs;
  logic [SLOT_W-1:0]              slot;
  logic [1:0]                     id_idx;
  logic [NUM_SRC-1:0]             en, steer, sw, irq_stat, fiq_stat;
  logic                           test_bit;
  logic [NUM_VEC-1:0][VEC_W-1:0]  vaddr;
  logic [NUM_VEC-1:0]             slot_en;
  logic [NUM_VEC-1:0][SRC_W-1:0]  slot_src;
  logic [VEC_W-1:0]               def_vec, cur_vec;
  logic [31:0]                    rd_val, rdata_q;

  irqv_decode #(.NUM_VEC(NUM_VEC), .SLOT_W(SLOT_W)) u_decode (
    .addr_i   (addr_i),
    .rs_o     (rs),
    .slot_o   (slot),
    .id_idx_o (id_idx)
  );

  irqv_srcregs #(.NUM_SRC(NUM_SRC)) u_srcregs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_set_i   (wr_i & rs.en_set),
    .en_clr_i   (wr_i & rs.en_clr),
    .steer_wr_i (wr_i & rs.steer),
    .sw_set_i   (wr_i & rs.sw_set),
    .sw_clr_i   (wr_i & rs.sw_clr),
    .test_wr_i  (wr_i & rs.test),
    .wdata_i    (wdata_i),
    .hw_i       (hw_irq_i),
    .en_o       (en),
    .steer_o    (steer),
    .sw_o       (sw),
    .test_o     (test_bit),
    .irq_stat_o (irq_stat),
    .fiq_stat_o (fiq_stat)
  );

  irqv_vecbank #(.NUM_VEC(NUM_VEC), .SLOT_W(SLOT_W), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_vecbank (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .vaddr_wr_i (wr_i & rs.vaddr),
    .vctl_wr_i  (wr_i & rs.vctl),
    .def_wr_i   (wr_i & rs.vec_def),
    .slot_i     (slot),
    .wdata_i    (wdata_i),
    .vaddr_o    (vaddr),
    .slot_en_o  (slot_en),
    .slot_src_o (slot_src),
    .def_o      (def_vec)
  );

  irqv_arbiter #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_arbiter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .irq_stat_i (irq_stat),
    .slot_en_i  (slot_en),
    .slot_src_i (slot_src),
    .vaddr_i    (vaddr),
    .def_i      (def_vec),
    .ack_i      (rd_i & rs.vec_cur),
    .eoi_i      (wr_i & rs.vec_cur),
    .vec_o      (cur_vec)
  );

  // read multiplexer; decode strobes are mutually exclusive
  always_comb begin
    rd_val = '0;
    if (rs.irq_stat) rd_val[NUM_SRC-1:0] = irq_stat;
    if (rs.fiq_stat) rd_val[NUM_SRC-1:0] = fiq_stat;
    if (rs.steer)    rd_val[NUM_SRC-1:0] = steer;
    if (rs.en_set)   rd_val[NUM_SRC-1:0] = en;
    if (rs.sw_set)   rd_val[NUM_SRC-1:0] = sw;
    if (rs.vec_cur)  rd_val[VEC_W-1:0]   = cur_vec;
    if (rs.vec_def)  rd_val[VEC_W-1:0]   = def_vec;
    if (rs.vaddr)    rd_val[VEC_W-1:0]   = vaddr[slot];
    if (rs.vctl) begin
      rd_val[SRC_W]     = slot_en[slot];
      rd_val[SRC_W-1:0] = slot_src[slot];
    end
    if (rs.test)     rd_val[0] = test_bit;
    if (rs.id) begin
      case (id_idx)
        2'd0:    rd_val[7:0] = CELL_ID[7:0];
        2'd1:    rd_val[7:0] = CELL_ID[15:8];
        2'd2:    rd_val[7:0] = CELL_ID[23:16];
        default: rd_val[7:0] = CELL_ID[31:24];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |irq_stat;
  assign fiq_o   = |fiq_stat;

  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && (rs == '0)) |=> (rdata_o == '0)); // R11

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

  localparam logic [31:0] TB_ID = 32'h0014_3190;
  localparam int NT = 31;

  // entry: {read?, hw lines, address, data (write value or expected read)}
  localparam logic [76:0] TBL [NT] = '{
    {1'b0, 32'h0000_0000, 12'h010, 32'h0000_00F0},  // R2 set 7:4
    {1'b1, 32'h0000_0000, 12'h010, 32'h0000_00F0},
    {1'b0, 32'h0000_0000, 12'h014, 32'h0000_0030},  // R2 clear 5:4
    {1'b1, 32'h0000_0000, 12'h010, 32'h0000_00C0},
    {1'b1, 32'h0000_0040, 12'h000, 32'h0000_0040},  // R4
    {1'b0, 32'h0000_0040, 12'h00C, 32'h0000_0080},  // R5 steer 7
    {1'b1, 32'h0000_00C0, 12'h000, 32'h0000_0040},
    {1'b1, 32'h0000_00C0, 12'h004, 32'h0000_0080},
    {1'b1, 32'h0000_00C0, 12'h00C, 32'h0000_0080},
    {1'b0, 32'h0000_00C0, 12'h018, 32'h0000_0100},  // R3
    {1'b1, 32'h0000_00C0, 12'h018, 32'h0000_0100},
    {1'b1, 32'h0000_00C0, 12'h000, 32'h0000_0040},
    {1'b0, 32'h0000_00C0, 12'h010, 32'h0000_0100},
    {1'b1, 32'h0000_00C0, 12'h000, 32'h0000_0140},
    {1'b0, 32'h0000_00C0, 12'h01C, 32'h0000_0100},
    {1'b1, 32'h0000_00C0, 12'h018, 32'h0000_0000},
    {1'b1, 32'h0000_00C0, 12'h000, 32'h0000_0040},
    {1'b0, 32'h0000_0000, 12'h104, 32'h1234_5678},  // R6
    {1'b1, 32'h0000_0000, 12'h104, 32'h1234_5678},
    {1'b0, 32'h0000_0000, 12'h204, 32'h0000_0026},
    {1'b1, 32'h0000_0000, 12'h204, 32'h0000_0026},
    {1'b0, 32'h0000_0000, 12'h204, 32'hFFFF_FFC7},
    {1'b1, 32'h0000_0000, 12'h204, 32'h0000_0007},
    {1'b0, 32'h0000_0000, 12'h034, 32'hCAFE_0000},  // R7 default
    {1'b1, 32'h0000_0000, 12'h034, 32'hCAFE_0000},
    {1'b1, 32'h0000_0000, 12'hFE0, 32'h0000_0090},  // R9
    {1'b1, 32'h0000_0000, 12'hFE4, 32'h0000_0031},
    {1'b1, 32'h0000_0000, 12'hFE8, 32'h0000_0014},
    {1'b1, 32'h0000_0000, 12'hFEC, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 12'h080, 32'h0000_0000},  // R11 unmapped
    {1'b1, 32'h0000_0000, 12'hFE2, 32'h0000_0000}   // R11 misaligned
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        wr, rd;
  logic [31:0] wdata, rdata, hw_irq;
  logic        irq_o, fiq_o;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(32), .NUM_VEC(16), .VEC_W(32), .CELL_ID(TB_ID)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .wr_i     (wr),
    .wdata_i  (wdata),
    .rd_i     (rd),
    .rdata_o  (rdata),
    .hw_irq_i (hw_irq),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp, input string what);
    logic [31:0] v;
    do_read(a, v);
    chk(req, v, exp, what);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic string req_of(input logic [11:0] a);
    if (a[11:4] == 8'hFE && a[1:0] == 2'b00) return "R9";
    if (a[11:8] == 4'h1 || a[11:8] == 4'h2) return "R6";
    case (a)
      12'h010, 12'h014: return "R2";
      12'h018, 12'h01C: return "R3";
      12'h000:          return "R4";
      12'h004, 12'h00C: return "R5";
      12'h034:          return "R7";
      default:          return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] idw;
    logic [31:0] b;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; hw_irq = '0;
    apply_reset();

    // R1: reset state with every hardware line high
    hw_irq = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R1", {31'b0, irq_o}, 32'h0, "irq_o after reset");
    chk("R1", {31'b0, fiq_o}, 32'h0, "fiq_o after reset");
    read_chk("R1", 12'h010, 32'h0, "enable mask");
    read_chk("R1", 12'h00C, 32'h0, "steering");
    read_chk("R1", 12'h018, 32'h0, "software requests");
    read_chk("R1", 12'h200, 32'h0, "slot 0 control");
    read_chk("R1", 12'h23C, 32'h0, "slot 15 control");
    read_chk("R10", 12'h300, 32'h0, "test control after reset");
    read_chk("R7", 12'h030, 32'h0, "vector with default zero");
    hw_irq = '0;

    // R10: test control bit
    do_write(12'h300, 32'h0000_0003);
    read_chk("R10", 12'h300, 32'h1, "test control readback");

    // table walk
    for (int i = 0; i < NT; i++) begin
      hw_irq = TBL[i][75:44];
      if (TBL[i][76]) read_chk(req_of(TBL[i][43:32]), TBL[i][43:32], TBL[i][31:0], $sformatf("table entry %0d", i));
      else            do_write(TBL[i][43:32], TBL[i][31:0]);
    end

    // R9: vendor field of the assembled word
    idw = '0;
    for (int k = 0; k < 4; k++) begin
      do_read(12'hFE0 + 12'(4 * k), b);
      idw[8*k +: 8] = b[7:0];
    end
    chk("R9", {24'b0, idw[19:12]}, 32'h43, "vendor code");

    // R7 / R8: vectored dispatch and nesting
    apply_reset();
    hw_irq = '0;
    do_write(12'h010, 32'h0000_0228);           // enable sources 3, 5, 9
    do_write(12'h100, 32'h0000_00A0); do_write(12'h200, 32'h0000_0023);
    do_write(12'h108, 32'h0000_00A2); do_write(12'h208, 32'h0000_0025);
    do_write(12'h114, 32'h0000_00A5); do_write(12'h214, 32'h0000_0029);
    do_write(12'h034, 32'h0000_00DD);
    read_chk("R7", 12'h030, 32'hDD, "no match gives default");
    hw_irq = 32'h0000_0020;
    read_chk("R8", 12'h030, 32'hA2, "slot 2 granted after a default read");
    hw_irq = 32'h0000_0220;
    read_chk("R8", 12'h030, 32'hDD, "slots 2 and 5 blocked while 2 in service");
    hw_irq = 32'h0000_0228;
    read_chk("R8", 12'h030, 32'hA0, "slot 0 preempts");
    do_write(12'h030, 32'h0);                   // ends slot 0
    hw_irq = 32'h0000_0220;
    read_chk("R8", 12'h030, 32'hDD, "slot 2 still in service after one end");
    hw_irq = 32'h0000_0200;
    do_write(12'h030, 32'h0);                   // ends slot 2
    read_chk("R8", 12'h030, 32'hA5, "slot 5 granted after slot 2 ends");
    do_write(12'h030, 32'h0);                   // ends slot 5
    do_write(12'h00C, 32'h0000_0200);           // source 9 to fast line
    read_chk("R7", 12'h030, 32'hDD, "fast-steered source not vectored");
    do_write(12'h200, 32'h0000_0003);           // slot 0 disabled
    hw_irq = 32'h0000_0008;
    read_chk("R6", 12'h030, 32'hDD, "disabled slot not vectored");
    do_write(12'h200, 32'h0000_0023);
    read_chk("R7", 12'h030, 32'hA0, "re-enabled slot vectored");
    do_write(12'h030, 32'h0);

    // R4: output falls at the edge that stores the enable clear
    hw_irq = 32'h0000_0002;
    do_write(12'h010, 32'h0000_0002);
    chk("R4", {31'b0, irq_o}, 32'h1, "irq_o with source 1 enabled");
    @(negedge clk);
    addr = 12'h014; wdata = 32'h0000_0002; wr = 1'b1;
    #1;
    chk("R4", {31'b0, irq_o}, 32'h1, "irq_o before the clearing edge");
    @(posedge clk);
    #1;
    chk("R4", {31'b0, irq_o}, 32'h0, "irq_o after the clearing edge");
    @(negedge clk);
    wr = 1'b0;

    // R5: steering moves the request to the fast line
    do_write(12'h00C, 32'h0000_0002);
    do_write(12'h010, 32'h0000_0002);
    chk("R5", {31'b0, fiq_o}, 32'h1, "fiq_o for steered source");
    chk("R5", {31'b0, irq_o}, 32'h0, "irq_o for steered source");
    hw_irq = '0;
    @(negedge clk);
    chk("R5", {31'b0, fiq_o}, 32'h0, "fiq_o follows the line low");

    // R3: software request alone drives the output
    do_write(12'h018, 32'h0000_0002);
    chk("R3", {31'b0, fiq_o}, 32'h1, "software request on fast line");
    do_write(12'h01C, 32'h0000_0002);
    chk("R3", {31'b0, fiq_o}, 32'h0, "software request cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule